// File: doc/BRIEF.md
# Sleep and Power-Down Mode Controller

This block sets the power state of a converter datapath from two mode bits in a configuration register. One bit requests a light sleep and the other a full power-down. From these bits the block drives an enable for the output current stage, a clock enable for the datapath, one enable per interpolation filter stage, and a flag that says whether the output samples can be trusted.

Sleep turns off only the output stage. Input latching and the filters keep running, so leaving sleep restores the output at once. Power-down stops the datapath clock and every filter stage. When power-down is released, the filters still hold stale contents. The block then runs a flush of `STAGES*STAGE_DEPTH` cycles. During the flush the filters are fed zeros, the output stage stays off and the valid flag stays low. The configuration port stays powered throughout and is not part of this block.

The mode bits are registered on each clock edge. Every output follows the registered mode bits and the flush counter, so each output responds to a mode change at the first clock edge after that change.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, and with both mode bits low, the block is in full operation: `out_en`=1, `dp_clk_en`=1, all bits of `filt_en`=1, `out_valid`=1, `flush_busy`=0, `filt_zero_feed`=0.
- R2: Sleep bit high and power-down bit low at an edge: from that edge on, `out_en`=0 while `dp_clk_en`, `filt_en` and `out_valid` stay 1.
- R3: The first edge that samples the sleep bit low, with no power-down or flush in progress, sets `out_en`=1. No wait period follows.
- R4: Power-down bit high at an edge: from that edge on, `dp_clk_en`=0, `filt_en`=0, `out_en`=0, `out_valid`=0 and `flush_busy`=0.
- R5: When both bits are high, the outputs are exactly those of power-down.
- R6: The first edge that samples the power-down bit low after it was high restores `dp_clk_en` and `filt_en` at once. That same edge starts a flush. `flush_busy` is then 1 and `out_valid` is 0 for exactly `STAGES*STAGE_DEPTH` cycles, after which `out_valid`=1.
- R7: While `flush_busy`=1, `out_en`=0 whatever the sleep bit is, and `filt_zero_feed`=1.
- R8: Power-down set again during a flush aborts the flush at that edge, giving the R4 state. The next release runs a flush of the full length.
- R9: Changes of the sleep bit during a flush do not change the flush length. When the flush ends, `out_en` equals the inverse of the registered sleep bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sleep | input | 1 | Sleep request bit from the configuration register |
| cfg_pdown | input | 1 | Power-down request bit from the configuration register |
| out_en | output | 1 | Output current stage enable |
| dp_clk_en | output | 1 | Datapath clock enable |
| filt_en | output | STAGES | Enable of each interpolation filter stage |
| filt_zero_feed | output | 1 | Feed zeros into the filters (flush running) |
| flush_busy | output | 1 | Flush in progress |
| out_valid | output | 1 | Output samples are valid |

## Verification
Two events can land on the same cycle: the last cycle of a flush and a change of the sleep bit. In the same way, a fresh power-down request can land on any cycle of a running flush. The bench provokes both collisions. Directed sequences toggle sleep while a flush counts down and assert power-down on chosen flush cycles, and biased random traffic on both mode bits finds further collisions. Every cycle, all outputs are compared with a bench model built from the requirements, which checks the flush length, the blanking of `out_en` and the restart of an aborted flush from the full count.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_SLEEP = 2'd1,
    PS_DOWN  = 2'd2,
    PS_FLUSH = 2'd3
  } pwr_state_e;

  function automatic int flush_cycles(input int stages, input int depth);
    return stages * depth;
  endfunction

endpackage

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_in,
  input  logic pdown_in,
  output logic sleep_q,
  output logic pdown_q
);

  logic sleep_d;
  logic pdown_d;

  always_comb begin
    sleep_d = sleep_in;
    pdown_d = pdown_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      pdown_q <= 1'b0;
    end else begin
      sleep_q <= sleep_d;
      pdown_q <= pdown_d;
    end
  end

endmodule

// File: rtl/pwr_flush_cnt.sv
module pwr_flush_cnt #(
  parameter int LEN   = 12,
  parameter int CNT_W = $clog2(LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdown_in,
  input  logic             pdown_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             busy
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(LEN);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (pdown_in) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (pdown_q) begin
      cnt_en = 1'b1;
      cnt_d  = FULL;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);

  a_r6_flush_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown_q && !pdown_in) |=> (cnt_q == FULL));

  a_r8_flush_abort: assert property (@(posedge clk) disable iff (!rst_n)
    pdown_in |=> !busy);

  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pdown_in && !pdown_q) |=> (int'(cnt_q) == int'($past(cnt_q)) - 1));

endmodule

// File: rtl/pwr_enable_gen.sv
module pwr_enable_gen
  import pwr_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_q,
  input  logic              pdown_q,
  input  logic              busy,
  output pwr_state_e        state,
  output logic              out_en,
  output logic              dp_clk_en,
  output logic [STAGES-1:0] filt_en,
  output logic              filt_zero_feed,
  output logic              out_valid
);

  always_comb begin
    if (pdown_q)      state = PS_DOWN;
    else if (busy)    state = PS_FLUSH;
    else if (sleep_q) state = PS_SLEEP;
    else              state = PS_RUN;
  end

  always_comb begin
    dp_clk_en      = (state != PS_DOWN);
    filt_zero_feed = (state == PS_FLUSH);
    out_valid      = (state == PS_RUN) || (state == PS_SLEEP);
    out_en         = (state == PS_RUN);
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign filt_en[g] = (state != PS_DOWN);
  end

  a_r7_blank_flush: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!out_en && filt_zero_feed && !out_valid));

  a_r4_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    pdown_q |-> (!dp_clk_en && !out_en && filt_en == '0));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int STAGES      = 3,
  parameter int STAGE_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sleep,
  input  logic              cfg_pdown,
  output logic              out_en,
  output logic              dp_clk_en,
  output logic [STAGES-1:0] filt_en,
  output logic              filt_zero_feed,
  output logic              flush_busy,
  output logic              out_valid
);

  localparam int FLUSH_LEN = flush_cycles(STAGES, STAGE_DEPTH);
  localparam int CNT_W     = $clog2(FLUSH_LEN + 1);

  logic             sleep_q;
  logic             pdown_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy;
  pwr_state_e       state;

  pwr_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_in (cfg_sleep),
    .pdown_in (cfg_pdown),
    .sleep_q  (sleep_q),
    .pdown_q  (pdown_q)
  );

  pwr_flush_cnt #(.LEN(FLUSH_LEN), .CNT_W(CNT_W)) u_flush (
    .clk      (clk),
    .rst_n    (rst_n),
    .pdown_in (cfg_pdown),
    .pdown_q  (pdown_q),
    .cnt_q    (cnt_q),
    .busy     (busy)
  );

  pwr_enable_gen #(.STAGES(STAGES)) u_en (
    .clk            (clk),
    .rst_n          (rst_n),
    .sleep_q        (sleep_q),
    .pdown_q        (pdown_q),
    .busy           (busy),
    .state          (state),
    .out_en         (out_en),
    .dp_clk_en      (dp_clk_en),
    .filt_en        (filt_en),
    .filt_zero_feed (filt_zero_feed),
    .out_valid      (out_valid)
  );

  assign flush_busy = busy;

  a_r5_pdown_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pdown && cfg_sleep) |=> (state == PS_DOWN && !dp_clk_en));

  a_r2_sleep_keeps_dp: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sleep && !cfg_pdown) |=> (!out_en && dp_clk_en));

  a_r3_sleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sleep && !cfg_pdown && !pdown_q && cnt_q <= CNT_W'(1)) |=> out_en);

endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;

  localparam int STAGES = 3;
  localparam int DEPTH  = 4;
  localparam int LEN    = STAGES * DEPTH;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_sleep, cfg_pdown;
  logic out_en, dp_clk_en, filt_zero_feed, flush_busy, out_valid;
  logic [STAGES-1:0] filt_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int m_pd, m_sl, m_cnt;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.STAGES(STAGES), .STAGE_DEPTH(DEPTH)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_sleep(cfg_sleep), .cfg_pdown(cfg_pdown),
    .out_en(out_en), .dp_clk_en(dp_clk_en), .filt_en(filt_en),
    .filt_zero_feed(filt_zero_feed), .flush_busy(flush_busy), .out_valid(out_valid)
  );

  function automatic logic [7:0] exp_vec();
    logic busy_e, valid_e;
    busy_e  = (m_cnt != 0);
    valid_e = (m_pd == 0) && !busy_e;
    return {3'b0, valid_e && (m_sl == 0), (m_pd == 0), (m_pd == 0),
            busy_e, valid_e};
  endfunction

  function automatic logic [7:0] act_vec();
    return {3'b0, out_en, dp_clk_en, &filt_en && (filt_en != '0),
            flush_busy && filt_zero_feed, out_valid};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, act_vec(), exp_vec());
    chk(req, {7'b0, filt_zero_feed}, {7'b0, flush_busy});
  endtask

  task automatic step(input logic sl, input logic pd);
    cfg_sleep = sl;
    cfg_pdown = pd;
    @(posedge clk);
    if (pd) m_cnt = 0;
    else if (m_pd != 0) m_cnt = LEN;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    m_pd = pd;
    m_sl = sl;
    @(negedge clk);
  endtask

  function automatic string tag();
    if (m_pd != 0) return "R4";
    if (m_cnt != 0) return "R7";
    if (m_sl != 0) return "R2";
    return "R3";
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    int lowcnt;
    seed = 32'h5eed;
    void'($urandom(seed));
    rst_n = 1'b0; cfg_sleep = 1'b0; cfg_pdown = 1'b0;
    m_pd = 0; m_sl = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    rst_n = 1'b1;
    step(0, 0);
    chk_all("R1 idle");

    // sleep enter/exit
    step(1, 0); chk_all("R2 sleep");
    chk("R2 dp stays", {7'b0, dp_clk_en}, 8'd1);
    step(0, 0); chk_all("R3 sleep exit");
    chk("R3 immediate", {7'b0, out_en}, 8'd1);

    // power-down and flush length
    step(0, 1); chk_all("R4 pdown");
    step(0, 1); chk_all("R4 pdown hold");
    step(0, 0); chk_all("R6 release");
    lowcnt = 0;
    while (!out_valid && lowcnt < LEN + 5) begin
      lowcnt++;
      chk_all("R6 flush");
      step(0, 0);
    end
    chk("R6 flush length", 8'(lowcnt), 8'(LEN));
    chk_all("R6 after flush");

    // both bits
    step(1, 1); chk_all("R5 both");
    chk("R5 dp off", {7'b0, dp_clk_en}, 8'd0);

    // sleep toggles during flush, end with sleep set
    step(1, 0); chk_all("R7 flush sleep");
    for (int i = 0; i < LEN - 1; i++) begin
      step(i[0], 0); chk_all("R9 toggle in flush");
    end
    step(1, 0); chk_all("R9 flush end sleep");
    chk("R9 out_en", {7'b0, out_en}, 8'd0);
    step(0, 0); chk_all("R9 wake");

    // abort mid flush then full restart
    step(0, 1); step(0, 0);
    repeat (LEN / 2) step(0, 0);
    step(0, 1); chk_all("R8 abort");
    chk("R8 busy cleared", {7'b0, flush_busy}, 8'd0);
    step(0, 0);
    lowcnt = 0;
    while (!out_valid && lowcnt < LEN + 5) begin
      lowcnt++; step(0, 0);
    end
    chk("R8 full restart", 8'(lowcnt), 8'(LEN));

    // abort on last flush cycle
    step(0, 1); step(0, 0);
    repeat (LEN - 1) step(0, 0);
    step(1, 1); chk_all("R8 abort last");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic sl, pd;
      sl = ($urandom % 3) == 0;
      pd = ($urandom % 16) == 0;
      step(sl, pd);
      chk_all(tag());
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule